// File: doc/BRIEF.md
# Inter-Group Synapse Table with Command Decoder

This block holds the sparse synapses that link one neuron group to another. Each source neuron owns a small set of fanout slots. A slot is addressed by concatenating the source group, the source neuron and the slot index. It holds a destination group, a destination neuron, a weight, a polarity flag and a valid bit. A spike router presents a slot address, and two cycles later it receives the decoded slot with a strobe that marks the result as valid.

Configuration arrives as a 4-bit operation code plus a 32-bit data word. The decoder repacks table-write words into slot entries. It turns intra-group weight words into a registered write toward a neuron group. It also answers reads of two statistics counters: routed spikes and neuron spikes. Each counter advances on its own strobe.

The field widths are parameters. The 32-bit word layout is fixed, and a narrower field takes the low bits of its slot in the word. The full-size configuration is 4/7/4 for group/neuron/fanout, which gives 32,768 slots. The default build uses 3/5/3, which gives 2,048 slots.

Top module: `sparse_syn_table`

## Requirements
- R1: After reset, res_valid, iw_valid and rd_valid are low, both counters read zero, and a lookup of any slot not yet written returns res_hit=0 with all result fields zero.
- R2: With cfg_valid high and cfg_op=0x0, the slot at address {wdata[0 +: GRP_W], wdata[4 +: NRN_W], wdata[11 +: FAN_W]} (group, neuron, fanout, from MSB down) is written. Its valid bit comes from wdata[31], destination group from wdata[27 +: GRP_W], destination neuron from wdata[20 +: NRN_W], weight from wdata[16 +: WT_W], and polarity from wdata[15].
- R3: A lookup sampled with lu_valid high at a clock edge raises res_valid right after the next edge, for exactly one cycle per request. Back-to-back requests give back-to-back results.
- R4: A result carries the stored slot: res_hit is the stored valid bit, and res_exc=1 means excitatory.
- R5: When a write and a lookup target the same slot at the same edge, the lookup returns the slot's contents from before that write. A lookup at the following edge returns the new contents.
- R6: With cfg_valid high and cfg_op=0x1, iw_valid is high for one cycle after the edge. It carries source neuron wdata[25 +: NRN_W], destination neuron wdata[18 +: NRN_W], weight wdata[14 +: WT_W], polarity wdata[13] and group wdata[9 +: GRP_W].
- R7: With cfg_valid high and cfg_op=0x2 (routed count) or 0x3 (neuron-spike count), rd_valid is high for one cycle after the edge. rd_data holds the selected counter as it stood before that edge, zero-extended to 32 bits.
- R8: Each counter grows by one at every edge where its strobe (routed_inc, spike_inc) is high, and wraps modulo 2^CNT_W.
- R9: Operation codes 0x4 to 0xF, and any word with cfg_valid low, change no slot and raise neither iw_valid nor rd_valid.
- R10: A later write to a slot replaces the earlier one completely. A slot written with valid bit 0 returns res_hit=0, together with the fields it was written with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration word present |
| cfg_op | input | 4 | Operation code (top nibble of the command word) |
| cfg_wdata | input | 32 | Configuration data word |
| routed_inc | input | 1 | Routed-spike counter strobe |
| spike_inc | input | 1 | Neuron-spike counter strobe |
| lu_valid | input | 1 | Lookup request |
| lu_group | input | GRP_W | Lookup source group |
| lu_neuron | input | NRN_W | Lookup source neuron |
| lu_fanout | input | FAN_W | Lookup fanout slot |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | Stored valid bit of the slot |
| res_dst_group | output | GRP_W | Destination group |
| res_dst_neuron | output | NRN_W | Destination neuron |
| res_weight | output | WT_W | Synaptic weight |
| res_exc | output | 1 | 1 = excitatory, 0 = inhibitory |
| iw_valid | output | 1 | Intra-group weight write strobe |
| iw_group | output | GRP_W | Target group |
| iw_src | output | NRN_W | Source neuron |
| iw_dst | output | NRN_W | Destination neuron |
| iw_weight | output | WT_W | Weight |
| iw_exc | output | 1 | Polarity of the intra-group weight |
| rd_valid | output | 1 | Counter read strobe |
| rd_data | output | 32 | Counter value |

## Verification
A table write and a router lookup can land on the same slot at the same clock edge. This is the case where stale or fresh data could leak out. The bench provokes it in a directed sequence, and again throughout a long random run in which most addresses come from a pool of eight slots, so collisions are frequent. A bench-side model records each lookup's expected result before it applies that cycle's write. A result that shows the fresh entry at a collision therefore counts as a failure tagged with the collision requirement. The same model also judges counter reads that coincide with counter strobes by their pre-edge value.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [3:0] {
    OP_TBL_WR     = 4'h0,
    OP_IW_WR      = 4'h1,
    OP_RD_ROUTED  = 4'h2,
    OP_RD_SPIKES  = 4'h3
  } op_e;

  // table-write word: fixed slot positions (LSB of each slot)
  localparam int TW_VALID = 31;
  localparam int TW_DGRP  = 27;
  localparam int TW_DNRN  = 20;
  localparam int TW_WT    = 16;
  localparam int TW_EXC   = 15;
  localparam int TW_FAN   = 11;
  localparam int TW_SNRN  = 4;
  localparam int TW_SGRP  = 0;

  // intra-weight word: fixed slot positions
  localparam int IW_SNRN  = 25;
  localparam int IW_DNRN  = 18;
  localparam int IW_WT    = 14;
  localparam int IW_EXC   = 13;
  localparam int IW_GRP   = 9;
endpackage

// File: rtl/sst_cmd_decode.sv
module sst_cmd_decode
  import sst_pkg::*;
#(
  parameter int GRP_W = 3,
  parameter int NRN_W = 5,
  parameter int FAN_W = 3,
  parameter int WT_W  = 4,
  localparam int ADDR_W = GRP_W + NRN_W + FAN_W,
  localparam int ENT_W  = 1 + GRP_W + NRN_W + WT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  input  logic [3:0]        cfg_op,
  input  logic [31:0]       cfg_wdata,
  output logic              tw_en,
  output logic [ADDR_W-1:0] tw_addr,
  output logic [ENT_W-1:0]  tw_entry,
  output logic              rd_en,
  output logic              rd_sel,
  output logic              iw_valid,
  output logic [GRP_W-1:0]  iw_group,
  output logic [NRN_W-1:0]  iw_src,
  output logic [NRN_W-1:0]  iw_dst,
  output logic [WT_W-1:0]   iw_weight,
  output logic              iw_exc
);
  logic unused_wbits;
  assign unused_wbits = ^cfg_wdata;

  logic iw_fire;

  always_comb begin
    tw_en    = cfg_valid && (cfg_op == OP_TBL_WR);
    iw_fire  = cfg_valid && (cfg_op == OP_IW_WR);
    rd_en    = cfg_valid && ((cfg_op == OP_RD_ROUTED) || (cfg_op == OP_RD_SPIKES));
    rd_sel   = (cfg_op == OP_RD_SPIKES);
    tw_addr  = {cfg_wdata[TW_SGRP +: GRP_W],
                cfg_wdata[TW_SNRN +: NRN_W],
                cfg_wdata[TW_FAN  +: FAN_W]};
    tw_entry = {cfg_wdata[TW_VALID],
                cfg_wdata[TW_DGRP +: GRP_W],
                cfg_wdata[TW_DNRN +: NRN_W],
                cfg_wdata[TW_WT   +: WT_W],
                cfg_wdata[TW_EXC]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iw_valid  <= 1'b0;
      iw_group  <= '0;
      iw_src    <= '0;
      iw_dst    <= '0;
      iw_weight <= '0;
      iw_exc    <= 1'b0;
    end else begin
      iw_valid <= iw_fire;
      if (iw_fire) begin
        iw_group  <= cfg_wdata[IW_GRP  +: GRP_W];
        iw_src    <= cfg_wdata[IW_SNRN +: NRN_W];
        iw_dst    <= cfg_wdata[IW_DNRN +: NRN_W];
        iw_weight <= cfg_wdata[IW_WT   +: WT_W];
        iw_exc    <= cfg_wdata[IW_EXC];
      end
    end
  end

  // R6
  iw_origin_chk: assert property (@(posedge clk) disable iff (rst)
    iw_valid |-> ($past(cfg_valid) && ($past(cfg_op) == OP_IW_WR)));

  // R9
  iw_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && (cfg_op > 4'h3)) |=> !iw_valid);
endmodule

// File: rtl/sst_store.sv
module sst_store #(
  parameter int ADDR_W = 11,
  parameter int ENT_W  = 14,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ENT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              out_valid,
  output logic [ENT_W-1:0]  out_data
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic [ENT_W-1:0] s1_data;
  logic             s1_written;
  logic             s1_valid;

  // block-RAM style array: read-before-write, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) s1_data <= mem[rd_addr];
  end

  // per-slot written flags stand in for clearing the array
  always_ff @(posedge clk) begin
    if (rst) begin
      written    <= '0;
      s1_written <= 1'b0;
      s1_valid   <= 1'b0;
    end else begin
      if (wr_en) written[wr_addr] <= 1'b1;
      s1_valid <= rd_en;
      if (rd_en) s1_written <= written[rd_addr];
    end
  end

  // unpack stage: strobe delayed alongside the data
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= s1_written ? s1_data : '0;
    end
  end

  // R3
  lat_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 out_valid);

  // R3
  lat_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ##1 !out_valid);

  // R1
  unwritten_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !written[rd_addr]) |=> ##1 (out_data == '0));
endmodule

// File: rtl/sst_stats.sv
module sst_stats #(
  parameter int CNT_W = 16,
  localparam int NUM_CNT = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inc_routed,
  input  logic        inc_spikes,
  input  logic        rd_en,
  input  logic        rd_sel,
  output logic        rd_valid,
  output logic [31:0] rd_data
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  assign inc = {inc_spikes, inc_routed};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt[i] <= '0;
      else if (inc[i]) cnt[i] <= cnt[i] + ONE;
    end

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      inc[i] |=> (cnt[i] == $past(cnt[i]) + ONE));

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !inc[i] |=> $stable(cnt[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= 32'(rd_sel ? cnt[1] : cnt[0]);
    end
  end

  // R7
  rd_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
endmodule

// File: rtl/sparse_syn_table.sv
module sparse_syn_table #(
  parameter int GRP_W = 3,
  parameter int NRN_W = 5,
  parameter int FAN_W = 3,
  parameter int WT_W  = 4,
  parameter int CNT_W = 16,
  localparam int ADDR_W = GRP_W + NRN_W + FAN_W,
  localparam int ENT_W  = 1 + GRP_W + NRN_W + WT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic [3:0]       cfg_op,
  input  logic [31:0]      cfg_wdata,
  input  logic             routed_inc,
  input  logic             spike_inc,
  input  logic             lu_valid,
  input  logic [GRP_W-1:0] lu_group,
  input  logic [NRN_W-1:0] lu_neuron,
  input  logic [FAN_W-1:0] lu_fanout,
  output logic             res_valid,
  output logic             res_hit,
  output logic [GRP_W-1:0] res_dst_group,
  output logic [NRN_W-1:0] res_dst_neuron,
  output logic [WT_W-1:0]  res_weight,
  output logic             res_exc,
  output logic             iw_valid,
  output logic [GRP_W-1:0] iw_group,
  output logic [NRN_W-1:0] iw_src,
  output logic [NRN_W-1:0] iw_dst,
  output logic [WT_W-1:0]  iw_weight,
  output logic             iw_exc,
  output logic             rd_valid,
  output logic [31:0]      rd_data
);
  logic              tw_en;
  logic [ADDR_W-1:0] tw_addr;
  logic [ENT_W-1:0]  tw_entry;
  logic              st_rd_en;
  logic              st_rd_sel;
  logic [ENT_W-1:0]  res_entry;

  sst_cmd_decode #(
    .GRP_W(GRP_W), .NRN_W(NRN_W), .FAN_W(FAN_W), .WT_W(WT_W)
  ) u_dec (
    .clk(clk), .rst(rst),
    .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_wdata(cfg_wdata),
    .tw_en(tw_en), .tw_addr(tw_addr), .tw_entry(tw_entry),
    .rd_en(st_rd_en), .rd_sel(st_rd_sel),
    .iw_valid(iw_valid), .iw_group(iw_group), .iw_src(iw_src),
    .iw_dst(iw_dst), .iw_weight(iw_weight), .iw_exc(iw_exc)
  );

  sst_store #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(tw_en), .wr_addr(tw_addr), .wr_data(tw_entry),
    .rd_en(lu_valid), .rd_addr({lu_group, lu_neuron, lu_fanout}),
    .out_valid(res_valid), .out_data(res_entry)
  );

  sst_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst),
    .inc_routed(routed_inc), .inc_spikes(spike_inc),
    .rd_en(st_rd_en), .rd_sel(st_rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign {res_hit, res_dst_group, res_dst_neuron, res_weight, res_exc} = res_entry;

  // R7
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && (cfg_op == 4'h2 || cfg_op == 4'h3)) |=> rd_valid);
endmodule

// File: tb/sparse_syn_table_test.sv
`timescale 1ns/1ps
module sparse_syn_table_test;
  localparam int G = 3, N = 5, F = 3, W = 4, CW = 5;
  localparam int DEPTH = 1 << (G + N + F);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_valid = 1'b0;
  logic [3:0] cfg_op = '0;
  logic [31:0] cfg_wdata = '0;
  logic routed_inc = 1'b0, spike_inc = 1'b0, lu_valid = 1'b0;
  logic [G-1:0] lu_group = '0;
  logic [N-1:0] lu_neuron = '0;
  logic [F-1:0] lu_fanout = '0;
  logic res_valid, res_hit, res_exc, iw_valid, iw_exc, rd_valid;
  logic [G-1:0] res_dst_group, iw_group;
  logic [N-1:0] res_dst_neuron, iw_src, iw_dst;
  logic [W-1:0] res_weight, iw_weight;
  logic [31:0] rd_data;

  sparse_syn_table #(.GRP_W(G), .NRN_W(N), .FAN_W(F), .WT_W(W), .CNT_W(CW)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit          m_w  [DEPTH];
  bit          m_v  [DEPTH];
  int unsigned m_dg [DEPTH];
  int unsigned m_dn [DEPTH];
  int unsigned m_wt [DEPTH];
  bit          m_ex [DEPTH];
  int unsigned c_routed = 0, c_spikes = 0;

  // pipelined expectations
  bit p1_v = 0, p2_v = 0;
  logic [31:0] p1_e = '0, p2_e = '0;
  string p1_t = "R3", p2_t = "R3";

  function automatic logic [31:0] tw_word(bit v, int unsigned dg, int unsigned dn,
      int unsigned wt, bit ex, int unsigned fan, int unsigned sn, int unsigned sg);
    return {v, 4'(dg), 7'(dn), 4'(wt), ex, 4'(fan), 7'(sn), 4'(sg)};
  endfunction

  function automatic logic [31:0] iw_word(int unsigned sn, int unsigned dn,
      int unsigned wt, bit ex, int unsigned grp);
    return {7'(sn), 7'(dn), 4'(wt), ex, 4'(grp), 9'd0};
  endfunction

  function automatic int unsigned slot(int unsigned g, int unsigned n, int unsigned f);
    return (g << (N + F)) | (n << F) | f;
  endfunction

  function automatic logic [31:0] exp_entry(int unsigned a);
    if (!m_w[a]) return '0;
    return {18'd0, m_v[a], 3'(m_dg[a]), 5'(m_dn[a]), 4'(m_wt[a]), m_ex[a]};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive after a falling edge, check at the next falling edge
  task automatic step(bit cv, logic [3:0] op, logic [31:0] wd, bit lv,
      int unsigned g, int unsigned n, int unsigned f, bit ri, bit si);
    int unsigned la, wa;
    bit          iw_e, rd_e;
    logic [31:0] rd_exp;
    bit          new_v;
    logic [31:0] new_e;
    string       new_t, ctag;
    cfg_valid = cv; cfg_op = op; cfg_wdata = wd;
    lu_valid = lv; lu_group = G'(g); lu_neuron = N'(n); lu_fanout = F'(f);
    routed_inc = ri; spike_inc = si;
    la = slot(g, n, f);
    wa = slot(wd[3:0] & ((1 << G) - 1), wd[10:4] & ((1 << N) - 1), wd[14:11] & ((1 << F) - 1));
    new_v = lv;
    new_e = exp_entry(la);
    if (cv && op == 4'h0 && lv && wa == la) new_t = "R5";
    else if (!m_w[la]) new_t = "R1";
    else if (!m_v[la]) new_t = "R10";
    else new_t = "R4";
    if (cv && op == 4'h0) begin
      m_w[wa] = 1; m_v[wa] = wd[31];
      m_dg[wa] = wd[30:27] & ((1 << G) - 1);
      m_dn[wa] = wd[26:20] & ((1 << N) - 1);
      m_wt[wa] = wd[19:16] & ((1 << W) - 1);
      m_ex[wa] = wd[15];
    end
    iw_e = cv && op == 4'h1;
    rd_e = cv && (op == 4'h2 || op == 4'h3);
    rd_exp = (op == 4'h3) ? c_spikes : c_routed;
    ctag = (cv && op > 4'h3) || !cv ? "R9" : (op == 4'h1 ? "R6" : "R7");
    if (ri) c_routed = (c_routed + 1) % (1 << CW);
    if (si) c_spikes = (c_spikes + 1) % (1 << CW);
    p2_v = p1_v; p2_e = p1_e; p2_t = p1_t;
    p1_v = new_v; p1_e = new_e; p1_t = new_t;
    @(negedge clk);
    chk(res_valid == p2_v, "R3", "res_valid", 32'(res_valid), 32'(p2_v));
    if (p2_v)
      chk({res_hit, res_dst_group, res_dst_neuron, res_weight, res_exc} == p2_e[13:0],
          p2_t, "result entry",
          32'({res_hit, res_dst_group, res_dst_neuron, res_weight, res_exc}), p2_e);
    chk(iw_valid == iw_e, ctag, "iw_valid", 32'(iw_valid), 32'(iw_e));
    if (iw_e)
      chk({iw_src, iw_dst, iw_weight, iw_exc, iw_group} ==
          {N'(wd[31:25]), N'(wd[24:18]), W'(wd[17:14]), wd[13], G'(wd[12:9])},
          "R6", "iw fields", 32'({iw_src, iw_dst, iw_weight, iw_exc, iw_group}),
          32'({N'(wd[31:25]), N'(wd[24:18]), W'(wd[17:14]), wd[13], G'(wd[12:9])}));
    chk(rd_valid == rd_e, ctag, "rd_valid", 32'(rd_valid), 32'(rd_e));
    if (rd_e) chk(rd_data == rd_exp, "R8", "counter value", rd_data, rd_exp);
  endtask

  task automatic idle(int cyc);
    for (int i = 0; i < cyc; i++) step(0, 4'h0, '0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned pool [8];
    void'($urandom(32'h5EED_2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    chk(res_valid == 0, "R1", "res_valid after reset", 32'(res_valid), 0);
    chk(iw_valid == 0, "R1", "iw_valid after reset", 32'(iw_valid), 0);
    chk(rd_valid == 0, "R1", "rd_valid after reset", 32'(rd_valid), 0);
    step(1, 4'h2, '0, 1, 0, 0, 0, 0, 0);
    step(1, 4'h3, '0, 1, 7, 31, 7, 0, 0);
    step(0, 4'h0, '0, 1, 3, 9, 2, 0, 0);
    idle(2);
    // R2 / R5: write and lookup same slot at one edge, then again
    step(1, 4'h0, tw_word(1, 5, 17, 9, 1, 2, 9, 3), 1, 3, 9, 2, 0, 0);
    step(0, 4'h0, '0, 1, 3, 9, 2, 0, 0);
    // R3: back-to-back lookups
    step(1, 4'h0, tw_word(1, 2, 30, 15, 0, 7, 31, 7), 1, 7, 31, 7, 0, 0);
    step(0, 4'h0, '0, 1, 7, 31, 7, 0, 0);
    step(0, 4'h0, '0, 1, 3, 9, 2, 0, 0);
    idle(2);
    // R10: overwrite with valid bit clear
    step(1, 4'h0, tw_word(0, 6, 4, 3, 1, 2, 9, 3), 0, 0, 0, 0, 0, 0);
    step(0, 4'h0, '0, 1, 3, 9, 2, 0, 0);
    // R9: unknown op and idle cfg must not write slot (1,1,1)
    step(1, 4'h7, tw_word(1, 1, 1, 1, 1, 1, 1, 1), 0, 0, 0, 0, 0, 0);
    step(1, 4'hF, iw_word(3, 4, 5, 1, 2), 0, 0, 0, 0, 0, 0);
    step(0, 4'h0, tw_word(1, 1, 1, 1, 1, 1, 1, 1), 0, 0, 0, 0, 0, 0);
    step(0, 4'h0, '0, 1, 1, 1, 1, 0, 0);
    idle(2);
    // R6: intra-group weight write
    step(1, 4'h1, iw_word(21, 6, 11, 1, 5), 0, 0, 0, 0, 0, 0);
    step(1, 4'h1, iw_word(0, 31, 0, 0, 7), 0, 0, 0, 0, 0, 0);
    // R8: wrap of routed counter, read during increment
    for (int i = 0; i < 33; i++) step(0, 4'h0, '0, 0, 0, 0, 0, 1, i[0]);
    step(1, 4'h2, '0, 0, 0, 0, 0, 1, 0);
    step(1, 4'h3, '0, 0, 0, 0, 0, 0, 1);
    step(1, 4'h2, '0, 0, 0, 0, 0, 0, 0);
    idle(2);
    // random traffic with a small hot pool to force collisions (R5)
    for (int i = 0; i < 8; i++) pool[i] = $urandom % DEPTH;
    for (int i = 0; i < 4000; i++) begin
      int unsigned r, wsl, lsl;
      logic [3:0] op;
      logic [31:0] wd;
      r = $urandom % 100;
      op = (r < 45) ? 4'h0 : (r < 55) ? 4'h1 : (r < 65) ? 4'h2 :
           (r < 72) ? 4'h3 : (r < 78) ? 4'(4 + $urandom % 12) : 4'h0;
      wsl = ($urandom % 4 != 0) ? pool[$urandom % 8] : $urandom % DEPTH;
      lsl = ($urandom % 4 != 0) ? pool[$urandom % 8] : $urandom % DEPTH;
      if (op == 4'h1)
        wd = iw_word($urandom % 32, $urandom % 32, $urandom % 16, $urandom % 2, $urandom % 8);
      else
        wd = tw_word($urandom % 4 != 0, $urandom % 8, $urandom % 32, $urandom % 16,
                     $urandom % 2, wsl % 8, (wsl >> F) % 32, wsl >> (N + F));
      step(r < 90, op, wd, $urandom % 3 != 0, lsl >> (N + F), (lsl >> F) % 32, lsl % 8,
           $urandom % 2, $urandom % 3 == 0);
    end
    idle(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule